// File: doc/BRIEF.md
# Banked PSG Register File

This block is the host-side register file of a three-channel programmable sound generator. A host bus writes in two steps: first a register number into an address latch, then a data byte that lands in the selected register. Reads return the register that the latch currently selects. While the chip is deselected, or the latch points outside the 16-entry window, a read returns the idle value 0xFF.

The block has 32 byte registers, split into two banks of 16. Writing the mode/shape register (latch value 0x0D) with a mode nibble whose upper three bits are 101 puts the block into expanded mode. Bit 4 of that byte then selects bank 1, which adds 16 to every later address. In compatibility mode the bank offset is always zero.

The block decodes the stored bytes into fields for the sound generators. These are the tone and noise enables for each channel, the noise period, the volume for each channel, the envelope shape and the two noise mask bytes. The noise period and volume fields widen in expanded mode.

Top module: `psg_banked_regs`

## Requirements
- R1: After reset the block is in compatibility mode (`expanded_o`=0, `bank_o`=0, `shape_o`=0), the address latch holds 0 and every register reads back 0x00.
- R2: An address-phase write (`sel_i`=1, `wr_i`=1, `addr_phase_i`=1) loads `wdata_i` into the address latch. A data-phase write (`addr_phase_i`=0) stores `wdata_i` at latch plus bank offset on the same clock edge. A read then returns that byte combinationally.
- R3: When expanded support is enabled, storing a mode byte whose bits [7:5] equal 3'b101 into register 0x0D raises `expanded_o` from the next cycle. Any other pattern in bits [7:5] leaves the block in compatibility mode.
- R4: In expanded mode, bit 4 of the mode byte drives `bank_o`, and bank 1 maps latch values 0x0..0xF onto registers 0x10..0x1F. In compatibility mode `bank_o` is 0 even when bit 4 is set, so bank-0 registers are addressed.
- R5: Latch value 0x0D always addresses the mode/shape register in either bank, so expanded mode can always be left.
- R6: Registers 0x1B, 0x1C, 0x1E and 0x1F (latch 0xB, 0xC, 0xE, 0xF in bank 1) are reserved: a write to one of them stores 0, and a read returns 0x00.
- R7: With `sel_i`=0, or with latch bits [7:4] not all zero, `rdata_o` is 0xFF and data writes change no register.
- R8: Enable register 0x07 bits [2:0] drive `tone_en_o` for channels 0..2, and bits [5:3] drive `noise_en_o` for channels 0..2.
- R9: `noise_period_o` is bits [4:0] of register 0x06 with the upper bits zero in compatibility mode, and the full 8 bits of register 0x06 in expanded mode.
- R10: The volume of channel n comes from register 0x08+n and occupies `vol_o[5n+4:5n]`. It is bits [3:0] with bit 4 forced to 0 in compatibility mode, and bits [4:0] in expanded mode.
- R11: `noise_and_o` and `noise_or_o` carry the full bytes of registers 0x19 and 0x1A.
- R12: `shape_o` equals bits [3:0] of the mode/shape register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| addr_phase_i | input | 1 | 1: write goes to address latch, 0: write goes to register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0xFF when idle |
| expanded_o | output | 1 | Expanded mode active |
| bank_o | output | 1 | Selected register bank |
| shape_o | output | 4 | Envelope shape |
| tone_en_o | output | 3 | Tone enable per channel |
| noise_en_o | output | 3 | Noise enable per channel |
| noise_period_o | output | 8 | Noise period, width by mode |
| vol_o | output | 15 | Volume of each channel, 5 bits each |
| noise_and_o | output | 8 | Noise AND mask |
| noise_or_o | output | 8 | Noise OR mask |

## Verification
Assertions watch on every cycle:
- the latch load;
- that a 101 mode write is followed by expanded mode;
- that a reserved write leaves a zero;
- the idle read value;
- that the narrow noise and volume fields and bank 0 hold in compatibility mode.

Only the bench scenarios can show the rest. These are:
- that bank 1 really shifts addresses without disturbing the bank-0 register at the same latch value;
- that latch 0x0D reaches the mode register from bank 1;
- that a deselected or out-of-window write leaves the stored bytes intact;
- that the widened fields return to narrow form when expanded mode is left.

// File: rtl/psg_reg_pkg.sv
package psg_reg_pkg;
  localparam int REG_W     = 8;
  localparam int BANK_REGS = 16;
  localparam int NUM_BANKS = 2;
  localparam int NUM_REGS  = BANK_REGS * NUM_BANKS;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int LOC_W     = $clog2(BANK_REGS);
  localparam int NUM_CH    = 3;
  localparam int VOL_W     = 5;
  localparam int VOL_W_CMP = 4;
  localparam int NP_W_CMP  = 5;

  localparam logic [IDX_W-1:0] IDX_NOISE_PER = 5'h06;
  localparam logic [IDX_W-1:0] IDX_ENABLE    = 5'h07;
  localparam logic [IDX_W-1:0] IDX_VOL0      = 5'h08;
  localparam logic [IDX_W-1:0] IDX_MODE      = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_NAND      = 5'h19;
  localparam logic [IDX_W-1:0] IDX_NOR       = 5'h1A;

  localparam logic [2:0] EXP_KEY = 3'b101;

  function automatic logic is_reserved(input logic [IDX_W-1:0] idx);
    return (idx == 5'h1B) || (idx == 5'h1C) || (idx == 5'h1D) ||
           (idx == 5'h1E) || (idx == 5'h1F);
  endfunction
endpackage

// File: rtl/psg_addr_latch.sv
module psg_addr_latch
  import psg_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             bank_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [REG_W-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= '0;
    else if (load_i) latch_q <= wdata_i;
  end

  assign active_o = (latch_q[REG_W-1:LOC_W] == '0);

  // mode register is reachable from either bank
  always_comb begin
    if (latch_q[LOC_W-1:0] == IDX_MODE[LOC_W-1:0]) idx_o = IDX_MODE;
    else                                           idx_o = {bank_i, latch_q[LOC_W-1:0]};
  end

  p_latch_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> latch_q == $past(wdata_i));
endmodule

// File: rtl/psg_reg_array.sv
module psg_reg_array
  import psg_reg_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
    localparam logic RSV = is_reserved(IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   regs_q[g] <= '0;
      else if (we_i && idx_i == IDX) regs_q[g] <= RSV ? '0 : wdata_i;
    end
  end

  assign regs_o = regs_q;

  p_rsv_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_reserved(idx_i)) |=> regs_q[$past(idx_i)] == '0);
endmodule

// File: rtl/psg_field_decode.sv
module psg_field_decode
  import psg_reg_pkg::*;
#(
  parameter bit EXP_EN = 1'b1
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs_i,
  output logic                           expanded_o,
  output logic                           bank_o,
  output logic [3:0]                     shape_o,
  output logic [NUM_CH-1:0]              tone_en_o,
  output logic [NUM_CH-1:0]              noise_en_o,
  output logic [REG_W-1:0]               noise_period_o,
  output logic [NUM_CH*VOL_W-1:0]        vol_o,
  output logic [REG_W-1:0]               noise_and_o,
  output logic [REG_W-1:0]               noise_or_o
);
  logic [REG_W-1:0] mode;
  logic [REG_W-1:0] np_raw;
  logic [REG_W-1:0] en_raw;

  assign mode       = regs_i[IDX_MODE];
  assign np_raw     = regs_i[IDX_NOISE_PER];
  assign en_raw     = regs_i[IDX_ENABLE];
  assign expanded_o = EXP_EN && (mode[7:5] == EXP_KEY);
  assign bank_o     = expanded_o & mode[4];
  assign shape_o    = mode[3:0];
  assign tone_en_o  = en_raw[NUM_CH-1:0];
  assign noise_en_o = en_raw[2*NUM_CH-1:NUM_CH];

  assign noise_period_o = expanded_o ? np_raw
                                     : {{(REG_W-NP_W_CMP){1'b0}}, np_raw[NP_W_CMP-1:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_vol
    logic [REG_W-1:0] v;
    assign v = regs_i[IDX_VOL0 + IDX_W'(c)];
    assign vol_o[c*VOL_W +: VOL_W] = expanded_o ? v[VOL_W-1:0]
                                                : {1'b0, v[VOL_W_CMP-1:0]};
  end

  assign noise_and_o = regs_i[IDX_NAND];
  assign noise_or_o  = regs_i[IDX_NOR];
endmodule

// File: rtl/psg_banked_regs.sv
module psg_banked_regs
  import psg_reg_pkg::*;
#(
  parameter bit EXP_EN = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sel_i,
  input  logic                    wr_i,
  input  logic                    addr_phase_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic                    expanded_o,
  output logic                    bank_o,
  output logic [3:0]              shape_o,
  output logic [NUM_CH-1:0]       tone_en_o,
  output logic [NUM_CH-1:0]       noise_en_o,
  output logic [REG_W-1:0]        noise_period_o,
  output logic [NUM_CH*VOL_W-1:0] vol_o,
  output logic [REG_W-1:0]        noise_and_o,
  output logic [REG_W-1:0]        noise_or_o
);
  logic                           active;
  logic [IDX_W-1:0]               idx;
  logic                           latch_ld;
  logic                           reg_we;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;

  assign latch_ld = sel_i & wr_i & addr_phase_i;
  assign reg_we   = sel_i & wr_i & ~addr_phase_i & active;

  psg_addr_latch u_latch (
    .clk_i, .rst_ni, .load_i(latch_ld), .wdata_i, .bank_i(bank_o),
    .active_o(active), .idx_o(idx)
  );

  psg_reg_array u_array (
    .clk_i, .rst_ni, .we_i(reg_we), .idx_i(idx), .wdata_i, .regs_o(regs)
  );

  psg_field_decode #(.EXP_EN(EXP_EN)) u_decode (
    .regs_i(regs), .expanded_o, .bank_o, .shape_o, .tone_en_o, .noise_en_o,
    .noise_period_o, .vol_o, .noise_and_o, .noise_or_o
  );

  assign rdata_o = (sel_i && active) ? regs[idx] : {REG_W{1'b1}};

  p_idle_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> rdata_o == 8'hFF);
  p_enter_exp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we && idx == IDX_MODE && wdata_i[7:5] == EXP_KEY && EXP_EN) |=> expanded_o);
  p_bank_compat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expanded_o |-> !bank_o);
  p_np_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expanded_o |-> noise_period_o[7:5] == 3'b000);
  p_vol_width_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expanded_o |-> (vol_o[4] | vol_o[9] | vol_o[14]) == 1'b0);
endmodule

// File: tb/psg_banked_regs_bench.sv
module psg_banked_regs_bench;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0, ap = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd, np, nand_m, nor_m;
  logic exp_m, bank;
  logic [3:0] shape;
  logic [2:0] ten, nen;
  logic [14:0] vol;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psg_banked_regs u_psg_banked_regs (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_phase_i(ap),
    .wdata_i(wd), .rdata_o(rd), .expanded_o(exp_m), .bank_o(bank),
    .shape_o(shape), .tone_en_o(ten), .noise_en_o(nen), .noise_period_o(np),
    .vol_o(vol), .noise_and_o(nand_m), .noise_or_o(nor_m)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic bus(logic s, logic phase, logic [7:0] d);
    @(negedge clk); sel = s; wr = 1; ap = phase; wd = d;
    @(negedge clk); wr = 0; sel = 1; #1;
  endtask

  task automatic wreg(logic [7:0] a, logic [7:0] d);
    bus(1, 1, a); bus(1, 0, d);
  endtask

  task automatic rreg(logic [7:0] a, string req, logic [7:0] exp_v);
    bus(1, 1, a); chk(req, rd, exp_v);
  endtask

  task automatic t_reset;
    chk("R1 expanded", exp_m, 0);
    chk("R1 bank", bank, 0);
    chk("R1 shape", shape, 0);
    @(negedge clk); sel = 1; #1;
    chk("R1 latch0 read", rd, 8'h00);
    rreg(8'h0D, "R1 mode reg", 8'h00);
  endtask

  task automatic t_compat;
    wreg(8'h07, 8'h2D);
    chk("R8 tone_en", ten, 3'b101);
    chk("R8 noise_en", nen, 3'b101);
    rreg(8'h07, "R2 readback", 8'h2D);
    wreg(8'h06, 8'hF7);
    chk("R9 np compat", np, 8'h17);
    wreg(8'h08, 8'h1F);
    wreg(8'h0A, 8'h13);
    chk("R10 vol0 compat", vol[4:0], 5'h0F);
    chk("R10 vol2 compat", vol[14:10], 5'h03);
    wreg(8'h0B, 8'h5A);
    wreg(8'h0D, 8'h13);
    chk("R4 compat bank", bank, 0);
    chk("R3 not expanded", exp_m, 0);
    chk("R12 shape", shape, 4'h3);
    rreg(8'h0B, "R4 compat bank0 addr", 8'h5A);
  endtask

  task automatic t_expanded;
    wreg(8'h0D, 8'hA5);
    chk("R3 expanded", exp_m, 1);
    chk("R4 bank0", bank, 0);
    chk("R12 shape exp", shape, 4'h5);
    chk("R9 np exp", np, 8'hF7);
    chk("R10 vol0 exp", vol[4:0], 5'h1F);
    wreg(8'h0D, 8'hB5);
    chk("R4 bank1", bank, 1);
    wreg(8'h09, 8'h3C);
    wreg(8'h0A, 8'hC3);
    chk("R11 and mask", nand_m, 8'h3C);
    chk("R11 or mask", nor_m, 8'hC3);
    rreg(8'h09, "R4 bank1 readback", 8'h3C);
    wreg(8'h0B, 8'h77);
    rreg(8'h0B, "R6 reserved 1B", 8'h00);
    wreg(8'h0E, 8'h44);
    rreg(8'h0E, "R6 reserved 1E", 8'h00);
    rreg(8'h0D, "R5 mode from bank1", 8'hB5);
    wreg(8'h0D, 8'hA5);
    chk("R5 back to bank0", bank, 0);
    rreg(8'h0B, "R4 bank0 untouched", 8'h5A);
    rreg(8'h0A, "R4 bank0 vol2", 8'h13);
    wreg(8'h0D, 8'h03);
    chk("R3 leave expanded", exp_m, 0);
    chk("R9 np narrow again", np, 8'h17);
    wreg(8'h0D, 8'h65);
    chk("R3 other key", exp_m, 0);
  endtask

  task automatic t_idle;
    bus(1, 1, 8'h07);
    @(negedge clk); sel = 0; #1;
    chk("R7 deselect read", rd, 8'hFF);
    bus(0, 0, 8'h00);
    rreg(8'h07, "R7 deselect write ignored", 8'h2D);
    bus(1, 1, 8'h27);
    chk("R7 out of window read", rd, 8'hFF);
    bus(1, 0, 8'h00);
    chk("R7 enables kept", ten, 3'b101);
    rreg(8'h07, "R7 window write ignored", 8'h2D);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset;
    t_compat;
    t_expanded;
    t_idle;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule